// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block decides which of six masters owns a shared parallel bus. Five masters sit off-chip and reach the arbiter through active-low request and grant pins. The sixth master is inside the chip and uses an active-high request and grant. A configuration bit for each master places it in a fast pool or a slow pool. Members of the fast pool take turns in strict rotation. The slow pool as a whole holds one extra seat in that rotation. Whoever occupies that seat is the slow-pool member whose turn has come, and the seat passes to the next slow-pool member after each use.

Requests, the bus-free flag and the enable are captured into registers at the rising clock edge. The decision is then taken from those registered copies, and the grant register is loaded at the next edge. A grant moves only when the bus is free or when the current owner has withdrawn its request. When nobody asks for the bus, the grant parks on the internal master. Clearing the enable turns the arbiter off so that an outside arbiter can take over. While it is off, every grant is inactive.

Top module: `bus_arb_2lvl`

## Requirements
- R1: During and directly after synchronous reset, every external grant pin reads high (inactive) and the internal grant reads 1, so the bus is parked on the internal master.
- R2: A low level on `req_ext_n[i]` means master i requests the bus. A low level on `gnt_ext_n[i]` grants it. Inputs are registered, so a request first changes the grant at the second rising edge after it is driven.
- R3: While enabled, exactly one of the six grants is active. External master i is vector index i (0 to 4) and the internal master is index 5.
- R4: While `bus_free` is low and the current owner keeps requesting, the grant does not change.
- R5: Fast-pool members are granted in rotation. The search starts at the position after the last rotation winner, in index order 0 to 5, and then reaches the slow-pool seat (position 6) before it wraps back to 0. With every master requesting in the fast pool and the bus free, the grants run 0,1,2,3,4,5,0.
- R6: The slow pool holds a single seat in the fast rotation, so only one slow-pool member can be granted per round. With masters 0 and 1 fast and masters 2 to 4 slow and all requesting, the grants run 0,1,2,0,1,3,0,1,4,0,1,2.
- R7: After a slow-pool member is granted, the seat moves to the next requesting slow-pool member in index order after it, wrapping from 5 to 0.
- R8: When no master requests and the arbiter is enabled, the grant goes to the internal master.
- R9: When `arb_enable` is low, all external grant pins are high and the internal grant is 0. This takes effect at the second rising edge after the enable falls, and the rotation positions are kept.
- R10: `pool_cfg[i]` = 1 places master i in the fast pool and 0 places it in the slow pool. Bit 5 belongs to the internal master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req_ext_n | input | 5 | External bus requests, active low |
| req_int | input | 1 | Internal master request, active high |
| bus_free | input | 1 | High when no transfer occupies the bus |
| pool_cfg | input | 6 | Per-master pool select, 1 = fast pool |
| arb_enable | input | 1 | High enables arbitration; low releases all grants |
| gnt_ext_n | output | 5 | External grants, active low |
| gnt_int | output | 1 | Internal master grant, active high |

## Verification
The assertions check several rules on every cycle. A one-hot grant while enabled, and no grant while disabled. A grant held while the bus is busy and its owner still asks. Parking when nothing is requested. A new winner that was actually requesting. The slow seat going to a slow-pool member. The exact order of a rotation cannot be seen by any single-cycle rule. That covers the one-seat share of the slow pool, the hand-off of the slow seat, and the two-edge pipeline delay. Only the bench's grant sequences show these. It also runs a long sweep against a cycle model over changing pool maps, request patterns and bus-free patterns.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
    localparam int EXT_CNT  = 5;
    localparam int REQ_CNT  = EXT_CNT + 1;
    localparam int SLOT_CNT = REQ_CNT + 1;
    localparam int PARK_IDX = EXT_CNT;
    localparam int LOW_SEAT = REQ_CNT;
    localparam int POS_W    = $clog2(SLOT_CNT);

    typedef logic [REQ_CNT-1:0]  req_vec_t;
    typedef logic [SLOT_CNT-1:0] slot_vec_t;
    typedef logic [POS_W-1:0]    pos_t;

    typedef enum logic {POOL_SLOW = 1'b0, POOL_FAST = 1'b1} pool_e;

    typedef struct packed {
        req_vec_t req;
        logic     bus_free;
        logic     enable;
    } arb_in_t;

    typedef struct packed {
        req_vec_t gnt;
        pos_t     fast_pos;
        pos_t     slow_pos;
    } arb_state_t;

    function automatic pos_t wrap_next(pos_t p, int modulus);
        if (int'(p) + 1 >= modulus) return '0;
        return pos_t'(p + 1'b1);
    endfunction

    function automatic req_vec_t one_hot(pos_t p);
        return req_vec_t'(1) << p;
    endfunction
endpackage

// File: rtl/bus_arb_rr_pick.sv
module bus_arb_rr_pick #(
    parameter int W  = 4,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  cand,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] win
);
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < W; k++) begin
            if (!found && cand[(int'(start) + k) % W]) begin
                found = 1'b1;
                win   = IW'((int'(start) + k) % W);
            end
        end
    end
endmodule

// File: rtl/bus_arb_in_stage.sv
module bus_arb_in_stage
    import bus_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [EXT_CNT-1:0] req_ext_n,
    input  logic               req_int,
    input  logic               bus_free,
    input  logic               arb_enable,
    output arb_in_t            in_q
);
    req_vec_t req_act;

    genvar g;
    generate
        for (g = 0; g < EXT_CNT; g++) begin : g_pin
            assign req_act[g] = ~req_ext_n[g];
        end
    endgenerate
    assign req_act[PARK_IDX] = req_int;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q.req      <= '0;
            in_q.bus_free <= 1'b1;
            in_q.enable   <= 1'b1;
        end else begin
            in_q.req      <= req_act;
            in_q.bus_free <= bus_free;
            in_q.enable   <= arb_enable;
        end
    end
endmodule

// File: rtl/bus_arb_2lvl.sv
module bus_arb_2lvl
    import bus_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [EXT_CNT-1:0] req_ext_n,
    input  logic               req_int,
    input  logic               bus_free,
    input  logic [REQ_CNT-1:0] pool_cfg,
    input  logic               arb_enable,
    output logic [EXT_CNT-1:0] gnt_ext_n,
    output logic               gnt_int
);
    localparam req_vec_t PARK_VEC = req_vec_t'(1) << PARK_IDX;

    arb_in_t    in_q;
    arb_state_t st_q, st_d;
    req_vec_t   fast_req, slow_req;
    slot_vec_t  seat_req;
    pos_t       fast_start, fast_win, slow_win;
    logic       fast_found, slow_found;
    logic       owner_busy, rearb;

    bus_arb_in_stage u_in (
        .clk        (clk),
        .rst        (rst),
        .req_ext_n  (req_ext_n),
        .req_int    (req_int),
        .bus_free   (bus_free),
        .arb_enable (arb_enable),
        .in_q       (in_q)
    );

    assign fast_req   = in_q.req & pool_cfg;
    assign slow_req   = in_q.req & ~pool_cfg;
    assign seat_req   = {|slow_req, fast_req};
    assign fast_start = wrap_next(st_q.fast_pos, SLOT_CNT);

    bus_arb_rr_pick #(.W(SLOT_CNT), .IW(POS_W)) u_fast (
        .cand  (seat_req),
        .start (fast_start),
        .found (fast_found),
        .win   (fast_win)
    );

    bus_arb_rr_pick #(.W(REQ_CNT), .IW(POS_W)) u_slow (
        .cand  (slow_req),
        .start (st_q.slow_pos),
        .found (slow_found),
        .win   (slow_win)
    );

    assign owner_busy = |(st_q.gnt & in_q.req);
    assign rearb      = in_q.enable && (in_q.bus_free || !owner_busy);

    always_comb begin
        st_d = st_q;
        if (!in_q.enable) begin
            st_d.gnt = '0;
        end else if (rearb) begin
            if (!fast_found) begin
                st_d.gnt = PARK_VEC;
            end else if (fast_win == pos_t'(LOW_SEAT)) begin
                st_d.gnt      = one_hot(slow_win);
                st_d.fast_pos = fast_win;
                st_d.slow_pos = wrap_next(slow_win, REQ_CNT);
            end else begin
                st_d.gnt      = one_hot(fast_win);
                st_d.fast_pos = fast_win;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.gnt      <= PARK_VEC;
            st_q.fast_pos <= pos_t'(LOW_SEAT);
            st_q.slow_pos <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_ext_n = ~st_q.gnt[EXT_CNT-1:0];
    assign gnt_int   = st_q.gnt[PARK_IDX];

    assert_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        in_q.enable |=> $onehot(st_q.gnt));

    assert_hold_busy_R4: assert property (@(posedge clk) disable iff (rst)
        (in_q.enable && !in_q.bus_free && owner_busy) |=> $stable(st_q.gnt));

    assert_winner_requested_R5: assert property (@(posedge clk) disable iff (rst)
        (rearb && (|in_q.req)) |=> |(st_q.gnt & $past(in_q.req)));

    assert_seat_to_slow_R6: assert property (@(posedge clk) disable iff (rst)
        (rearb && fast_found && fast_win == pos_t'(LOW_SEAT))
            |-> slow_found && !pool_cfg[slow_win]);

    assert_park_R8: assert property (@(posedge clk) disable iff (rst)
        (in_q.enable && in_q.req == '0) |=> st_q.gnt == PARK_VEC);

    assert_off_R9: assert property (@(posedge clk) disable iff (rst)
        !in_q.enable |=> (st_q.gnt == '0 && $stable(st_q.fast_pos)));
endmodule

// File: tb/tb_bus_arb_2lvl.sv
module tb_bus_arb_2lvl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] req_ext_n = 5'h1F;
    logic       req_int = 1'b0;
    logic       bus_free = 1'b1;
    logic [5:0] pool_cfg = 6'h3F;
    logic       arb_enable = 1'b1;
    logic [4:0] gnt_ext_n;
    logic       gnt_int;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bus_arb_2lvl dut (
        .clk(clk), .rst(rst), .req_ext_n(req_ext_n), .req_int(req_int),
        .bus_free(bus_free), .pool_cfg(pool_cfg), .arb_enable(arb_enable),
        .gnt_ext_n(gnt_ext_n), .gnt_int(gnt_int)
    );

    // reference model: registered inputs, grant, rotation positions
    logic [5:0] m_g, m_r;
    logic       m_f, m_e;
    int         m_hp, m_lp, hiw, lw;
    logic       cnd;

    always @(posedge clk) begin
        if (rst) begin
            m_g = 6'b100000; m_hp = 6; m_lp = 0;
            m_r = '0; m_f = 1'b1; m_e = 1'b1;
        end else begin
            if (!m_e) begin
                m_g = '0;
            end else if (m_f || (m_g & m_r) == '0) begin
                hiw = -1;
                for (int s = 1; s <= 7; s++) begin
                    cnd = ((m_hp + s) % 7 == 6) ? |(m_r & ~pool_cfg)
                        : (m_r[(m_hp + s) % 7] & pool_cfg[(m_hp + s) % 7]);
                    if (cnd && hiw < 0) hiw = (m_hp + s) % 7;
                end
                if (hiw < 0) begin
                    m_g = 6'b100000;
                end else if (hiw == 6) begin
                    lw = -1;
                    for (int s = 0; s < 6; s++)
                        if (m_r[(m_lp + s) % 6] && !pool_cfg[(m_lp + s) % 6] && lw < 0)
                            lw = (m_lp + s) % 6;
                    m_g = 6'(1) << lw; m_hp = 6; m_lp = (lw + 1) % 6;
                end else begin
                    m_g = 6'(1) << hiw; m_hp = hiw;
                end
            end
            m_r = {req_int, ~req_ext_n}; m_f = bus_free; m_e = arb_enable;
        end
    end

    function automatic logic [5:0] cur_gnt();
        return {gnt_int, ~gnt_ext_n};
    endfunction

    task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: grant actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(logic [5:0] r, logic f, logic e);
        req_ext_n = ~r[4:0]; req_int = r[5]; bus_free = f; arb_enable = e;
    endtask

    task automatic do_reset(logic [5:0] cfg);
        @(negedge clk); rst = 1'b1; drive(6'h00, 1'b1, 1'b1); pool_cfg = cfg;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    int seq6 [12] = '{0, 1, 2, 0, 1, 3, 0, 1, 4, 0, 1, 2};
    logic [31:0] lf = 32'h1234_5678;

    function automatic logic [31:0] nxt(logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13; y ^= y >> 17; y ^= y << 5;
        return y;
    endfunction

    initial begin
        // R1: reset state
        @(negedge clk); @(negedge clk);
        chk("R1 reset park", cur_gnt(), 6'b100000);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", cur_gnt(), 6'b100000);

        // R2: two-edge latency, active-low pins
        do_reset(6'h3F);
        drive(6'b000100, 1'b1, 1'b1);
        @(negedge clk); chk("R2 one edge", cur_gnt(), 6'b100000);
        @(negedge clk); chk("R2 two edges", cur_gnt(), 6'b000100);
        chk("R2 pin low", {1'b0, gnt_ext_n}, 6'b011011);

        // R5 / R3: full fast-pool rotation
        do_reset(6'h3F);
        drive(6'h3F, 1'b1, 1'b1);
        @(negedge clk);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            chk("R5 rotation", cur_gnt(), 6'(1) << (k % 6));
        end

        // R6 / R7: slow seat shared one per round
        do_reset(6'b000011);
        drive(6'b011111, 1'b1, 1'b1);
        @(negedge clk);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk("R6 R7 slow seat", cur_gnt(), 6'(1) << seq6[k]);
        end

        // R10: pool bit i belongs to master i
        do_reset(6'b010000);
        drive(6'b010001, 1'b1, 1'b1);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R10 pool map", cur_gnt(), (k % 2 == 0) ? 6'b010000 : 6'b000001);
        end

        // R4: hold while busy
        do_reset(6'h3F);
        drive(6'b001000, 1'b0, 1'b1);
        @(negedge clk); @(negedge clk);
        chk("R4 first owner", cur_gnt(), 6'b001000);
        drive(6'b001010, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); chk("R4 hold", cur_gnt(), 6'b001000);
        end
        drive(6'b000010, 1'b0, 1'b1);
        @(negedge clk); chk("R4 hold until seen", cur_gnt(), 6'b001000);
        @(negedge clk); chk("R4 handover", cur_gnt(), 6'b000010);

        // R8: park
        drive(6'b000000, 1'b0, 1'b1);
        @(negedge clk); @(negedge clk);
        chk("R8 park", cur_gnt(), 6'b100000);

        // R9: disable
        drive(6'b000101, 1'b1, 1'b0);
        @(negedge clk); @(negedge clk);
        chk("R9 off", cur_gnt(), 6'b000000);
        chk("R9 pins high", {1'b0, gnt_ext_n}, 6'b011111);
        @(negedge clk); @(negedge clk);
        chk("R9 still off", cur_gnt(), 6'b000000);
        drive(6'b000101, 1'b1, 1'b1);
        @(negedge clk); @(negedge clk);
        chk("R9 resume keeps position", cur_gnt(), 6'b000100);

        // sweep against cycle model
        do_reset(6'h3F);
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (c > 0) chk("R3 R5 R6 R7 sweep", cur_gnt(), m_g);
            lf = nxt(lf);
            if (c % 64 == 0) pool_cfg = lf[13:8];
            drive(lf[5:0], lf[6], lf[20:18] != 3'b000);
        end
        done = 1;
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end
endmodule